// File: doc/BRIEF.md
# Positional Result Belt

This block stands in for a general register file in a core that has no destination register numbers. Every result an operation produces is pushed onto the front of a fixed-length line of values. Everything already on the line moves back, and once the line is full the oldest value falls off the far end. A consumer names an operand by how far back it sits: position 0 is the newest value, position 1 the one before it, and so on. A stored value is never changed in place. It only ages.

An operation that yields several results raises several write enables in one cycle. Those results land together in port order. Several read ports select values by position combinationally from the registered belt, so a read sees the belt as it stood before any write in the same cycle. For call entry and return, a single save slot can capture the whole belt in one cycle, and a restore request reloads the belt from that slot in one cycle.

Top module: `belt_queue`

## Requirements
- R1: After reset every position is empty, so each read port returns data 0 with its invalid flag set.
- R2: When exactly one write enable is high, that value appears at position 0 on the next cycle and every older value moves back exactly one position with its value unchanged.
- R3: When k write enables are high in one cycle, the results are inserted in port order. The highest-numbered enabled port ends at position 0, the next lower enabled port at position 1, and so on. Older values shift back by k, and disabled ports leave no gap.
- R4: Once more than DEPTH values have been written, a value shifted past position DEPTH-1 is gone, and position DEPTH-1 holds the DEPTH-th most recent value.
- R5: A read of a position that has never been filled returns data 0 with `rd_bad` high. A read of a filled position returns its value with `rd_bad` low. Filled positions always form a contiguous run starting at 0.
- R6: Read data is combinational on the registered belt. A read in the same cycle as a write returns the contents from before that write.
- R7: In a cycle with no write enable and no restore, the belt contents and valid bits are unchanged.
- R8: A high `snap_req` copies the whole belt (values and valid bits) into the save slot as it stood before that cycle's writes. The writes of that cycle still apply to the belt.
- R9: A high `rest_req` loads the belt from the save slot, readable on the next cycle. Any write enables in that cycle are discarded.
- R10: When `snap_req` and `rest_req` are both high, the belt takes the previously saved image and the save slot takes the current belt, so the two are swapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | NWR | Per-port result valid; port p enabled when bit p is high |
| wr_data | input | NWR*W | Result values, port p in bits [p*W +: W] |
| rd_pos | input | NRD*PW | Belt position per read port, port r in bits [r*PW +: PW], PW = clog2(DEPTH) |
| rd_data | output | NRD*W | Value at the requested position, port r in bits [r*W +: W] |
| rd_bad | output | NRD | High when the requested position holds no value |
| snap_req | input | 1 | Save the whole belt into the save slot |
| rest_req | input | 1 | Reload the belt from the save slot |

## Verification
The bench concentrates on insertion order within a multi-result cycle, including enable patterns with a hole. A design that inverted the port order or left a gap would put values at the wrong positions. It also pushes more than DEPTH values, so an off-by-one at the tail would show up as a lost or duplicated oldest value. Every probe is taken while a write is pending, which catches a design that forwards new results to reads in the same cycle. Snapshot and restore are exercised together with writes and with each other: a snapshot taken after the writes, a restore that let writes leak through, or a simultaneous request that did not swap would each leave the wrong image readable.

// File: rtl/belt_pkg.sv
package belt_pkg;
    localparam int unsigned BELT_DEPTH_DEF = 8;
    localparam int unsigned BELT_WIDTH_DEF = 32;
    localparam int unsigned BELT_NWR_DEF   = 2;
    localparam int unsigned BELT_NRD_DEF   = 3;

    // width of a position index, never below one bit
    function automatic int unsigned pos_bits(input int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction
endpackage

// File: rtl/belt_shift.sv
module belt_shift #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned W     = 32,
    parameter int unsigned NWR   = 2
) (
    input  logic [DEPTH-1:0][W-1:0] cur_val,
    input  logic [DEPTH-1:0]        cur_vld,
    input  logic [NWR-1:0]          wr_en,
    input  logic [NWR*W-1:0]        wr_data,
    output logic [DEPTH-1:0][W-1:0] nxt_val,
    output logic [DEPTH-1:0]        nxt_vld
);
    int cnt;
    int rank [NWR];

    // rank of an enabled port = number of enabled ports above it
    always_comb begin
        cnt = 0;
        for (int p = NWR - 1; p >= 0; p--) begin
            rank[p] = cnt;
            cnt = cnt + (wr_en[p] ? 1 : 0);
        end
    end

    always_comb begin
        for (int j = 0; j < DEPTH; j++) begin
            nxt_val[j] = '0;
            nxt_vld[j] = 1'b0;
            for (int i = 0; i < DEPTH; i++) begin
                if (i + cnt == j) begin
                    nxt_val[j] = cur_val[i];
                    nxt_vld[j] = cur_vld[i];
                end
            end
            for (int p = 0; p < NWR; p++) begin
                if (wr_en[p] && rank[p] == j) begin
                    nxt_val[j] = wr_data[p*W +: W];
                    nxt_vld[j] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/belt_rdmux.sv
module belt_rdmux #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned W     = 32,
    parameter int unsigned PW    = 3
) (
    input  logic [DEPTH-1:0][W-1:0] val,
    input  logic [DEPTH-1:0]        vld,
    input  logic [PW-1:0]           pos,
    output logic [W-1:0]            data,
    output logic                    bad
);
    always_comb begin
        data = '0;
        bad  = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            if (pos == PW'(i) && vld[i]) begin
                data = val[i];
                bad  = 1'b0;
            end
        end
    end
endmodule

// File: rtl/belt_queue.sv
module belt_queue
    import belt_pkg::*;
#(
    parameter int unsigned DEPTH = BELT_DEPTH_DEF,
    parameter int unsigned W     = BELT_WIDTH_DEF,
    parameter int unsigned NWR   = BELT_NWR_DEF,
    parameter int unsigned NRD   = BELT_NRD_DEF,
    localparam int unsigned PW   = pos_bits(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NWR-1:0]    wr_en,
    input  logic [NWR*W-1:0]  wr_data,
    input  logic [NRD*PW-1:0] rd_pos,
    output logic [NRD*W-1:0]  rd_data,
    output logic [NRD-1:0]    rd_bad,
    input  logic              snap_req,
    input  logic              rest_req
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] val;
        logic [DEPTH-1:0]        vld;
        logic [DEPTH-1:0][W-1:0] sval;
        logic [DEPTH-1:0]        svld;
    } belt_st_t;

    belt_st_t st_d, st_q;

    logic [DEPTH-1:0][W-1:0] sh_val;
    logic [DEPTH-1:0]        sh_vld;

    belt_shift #(.DEPTH(DEPTH), .W(W), .NWR(NWR)) u_shift (
        .cur_val (st_q.val),
        .cur_vld (st_q.vld),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .nxt_val (sh_val),
        .nxt_vld (sh_vld)
    );

    always_comb begin
        st_d = st_q;
        if (snap_req) begin
            st_d.sval = st_q.val;
            st_d.svld = st_q.vld;
        end
        if (rest_req) begin
            st_d.val = st_q.sval;
            st_d.vld = st_q.svld;
        end else begin
            st_d.val = sh_val;
            st_d.vld = sh_vld;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        belt_rdmux #(.DEPTH(DEPTH), .W(W), .PW(PW)) u_rd (
            .val  (st_q.val),
            .vld  (st_q.vld),
            .pos  (rd_pos[r*PW +: PW]),
            .data (rd_data[r*W +: W]),
            .bad  (rd_bad[r])
        );
    end

    // R7: idle cycle leaves the belt untouched
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rest_req && wr_en == '0) |=> ($stable(st_q.val) && $stable(st_q.vld)));

    // R2: a single result lands at the front
    a_r2_front_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (!rest_req && $countones(wr_en) == 1) |=> st_q.vld[0]);

    for (genvar j = 0; j + 1 < DEPTH; j++) begin : g_age
        // R2: older values move back one place unchanged
        a_r2_age_one: assert property (@(posedge clk) disable iff (!rst_n)
            (!rest_req && $countones(wr_en) == 1) |=>
            (st_q.val[j+1] == $past(st_q.val[j]) && st_q.vld[j+1] == $past(st_q.vld[j])));
    end

    // R5: filled positions form a run from position 0
    a_r5_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld & (st_q.vld + DEPTH'(1))) == '0);

    // R9: restore reloads the saved image
    a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
        rest_req |=> (st_q.vld == $past(st_q.svld) && st_q.val == $past(st_q.sval)));

    // R8: snapshot captures the pre-write belt
    a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
        snap_req |=> (st_q.svld == $past(st_q.vld) && st_q.sval == $past(st_q.val)));
endmodule

// File: tb/tb_belt_queue.sv
module tb_belt_queue;
    localparam int DEPTH = 8;
    localparam int W     = 32;
    localparam int NWR   = 2;
    localparam int NRD   = 3;
    localparam int PW    = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NWR-1:0]    wr_en = '0;
    logic [NWR*W-1:0]  wr_data = '0;
    logic [NRD*PW-1:0] rd_pos = '0;
    logic [NRD*W-1:0]  rd_data;
    logic [NRD-1:0]    rd_bad;
    logic              snap_req = 1'b0;
    logic              rest_req = 1'b0;

    belt_queue #(.DEPTH(DEPTH), .W(W), .NWR(NWR), .NRD(NRD)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_pos(rd_pos), .rd_data(rd_data), .rd_bad(rd_bad),
        .snap_req(snap_req), .rest_req(rest_req)
    );

    always #4 clk = ~clk;

    typedef struct {
        int          port;
        int          pos;
        logic [W-1:0] data;
        logic        bad;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    int n_cmp = 0;
    int n_bad = 0;
    logic [W-1:0] m_val [DEPTH];
    logic         m_vld [DEPTH];
    logic [W-1:0] s_val [DEPTH];
    logic         s_vld [DEPTH];

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run hung, actual=running expected=done");
        finish_run();
    end

    // monitor: pop expected items and compare with the read ports
    task automatic monitor();
        while (exp_q.size() > 0) begin
            exp_t e = exp_q.pop_front();
            logic [W-1:0] ad = rd_data[e.port*W +: W];
            logic ab = rd_bad[e.port];
            n_cmp++;
            if (ad !== e.data || ab !== e.bad) begin
                n_bad++;
                $display("FAIL %s pos %0d port %0d: actual data=%h bad=%b expected data=%h bad=%b",
                         e.req, e.pos, e.port, ad, ab, e.data, e.bad);
            end
        end
    endtask

    // driver: read every position against the model
    task automatic probe(string req);
        for (int base = 0; base < DEPTH; base += NRD) begin
            for (int r = 0; r < NRD; r++) begin
                exp_t e;
                int p = (base + r) % DEPTH;
                rd_pos[r*PW +: PW] = PW'(p);
                e.port = r;
                e.pos  = p;
                e.data = m_vld[p] ? m_val[p] : '0;
                e.bad  = !m_vld[p];
                e.req  = req;
                exp_q.push_back(e);
            end
            #1;
            monitor();
        end
    endtask

    task automatic model_push(logic [W-1:0] d);
        for (int i = DEPTH - 1; i > 0; i--) begin
            m_val[i] = m_val[i-1];
            m_vld[i] = m_vld[i-1];
        end
        m_val[0] = d;
        m_vld[0] = 1'b1;
    endtask

    // one cycle of stimulus; probes are taken before the edge (pre-write view)
    task automatic cycle(logic [NWR-1:0] en, logic [W-1:0] d0, logic [W-1:0] d1,
                         logic sn, logic rs, string req);
        @(negedge clk);
        wr_en    = en;
        wr_data  = {d1, d0};
        snap_req = sn;
        rest_req = rs;
        probe(req);
        @(posedge clk);
        begin
            logic [W-1:0] tv [DEPTH];
            logic         tl [DEPTH];
            for (int i = 0; i < DEPTH; i++) begin
                tv[i] = s_val[i];
                tl[i] = s_vld[i];
            end
            if (sn) begin
                for (int i = 0; i < DEPTH; i++) begin
                    s_val[i] = m_val[i];
                    s_vld[i] = m_vld[i];
                end
            end
            if (rs) begin
                for (int i = 0; i < DEPTH; i++) begin
                    m_val[i] = tv[i];
                    m_vld[i] = tl[i];
                end
            end else begin
                if (en[0]) model_push(d0);
                if (en[1]) model_push(d1);
            end
        end
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            m_val[i] = '0; m_vld[i] = 1'b0;
            s_val[i] = '0; s_vld[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        probe("R1");
        // R2 R5 R6: single results, partially filled belt
        for (int n = 0; n < 5; n++)
            cycle(2'b01, 32'h100 + n, 32'hdead0000, 1'b0, 1'b0, "R2 R5 R6");
        cycle(2'b00, '0, '0, 1'b0, 1'b0, "R2 R5");
        // R3: two results together, then each port alone (no gap)
        cycle(2'b11, 32'h200, 32'h201, 1'b0, 1'b0, "R3 R6");
        cycle(2'b10, 32'hbad0, 32'h210, 1'b0, 1'b0, "R3");
        cycle(2'b01, 32'h220, 32'hbad1, 1'b0, 1'b0, "R3");
        // R4: overflow past the tail
        for (int n = 0; n < 6; n++)
            cycle(n[0] ? 2'b11 : 2'b01, 32'h300 + n, 32'h380 + n, 1'b0, 1'b0, "R4");
        // R7: idle
        cycle(2'b00, 32'h1, 32'h2, 1'b0, 1'b0, "R4");
        cycle(2'b00, '0, '0, 1'b0, 1'b0, "R7");
        // R8: snapshot with a write in the same cycle
        cycle(2'b01, 32'h400, '0, 1'b1, 1'b0, "R7");
        cycle(2'b11, 32'h410, 32'h411, 1'b0, 1'b0, "R8");
        // R9: restore, then restore with writes that must be dropped
        cycle(2'b00, '0, '0, 1'b0, 1'b1, "R8");
        cycle(2'b01, 32'h420, '0, 1'b0, 1'b0, "R9");
        cycle(2'b11, 32'h430, 32'h431, 1'b0, 1'b1, "R9");
        // R10: snapshot and restore together swap
        cycle(2'b01, 32'h440, '0, 1'b0, 1'b0, "R9");
        cycle(2'b00, '0, '0, 1'b1, 1'b1, "R10");
        cycle(2'b00, '0, '0, 1'b0, 1'b1, "R10");
        cycle(2'b00, '0, '0, 1'b0, 1'b0, "R10");
        @(negedge clk);
        wr_en = '0; snap_req = 1'b0; rest_req = 1'b0;
        probe("R10");
        finish_run();
    end
endmodule